// File: doc/BRIEF.md
# Two-Way Microsequencer with Opcode Dispatch

This block produces the address of the next microinstruction for a microprogrammed control unit. Every control word holds two candidate successors, a selector naming one status line, and a dispatch flag. On each clock edge the sequencer tests the chosen status line. It takes the first candidate when that line is 1 and the second when it is 0. When the dispatch flag is set, it adds the six opcode bits of the instruction word to the chosen address. The result is loaded into the micro-PC.

The next-address fields of a small sample control program are built into the block, so that a fetch/decode trace can be run against it. The program has 19 words. Addresses 0 to 4 fetch the instruction in two byte reads and then dispatch. A table of eight per-opcode entries starts at address 5. Helper steps for the conditional branch, the store and the load follow the table. Waiting on memory is written as a word that jumps to itself, so the micro-PC advances on every edge and has no stall input.

Top module: `microseq_top`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `upc` becomes 0.
- R2: A memory-access word that tests the wait line (addresses 1, 3, 16, 17) goes to its second candidate when `mem_wait` is 0: 1 goes to 2, 3 goes to 4, 16 goes to 0, and 17 goes to 18.
- R3: Unconditional words ignore all status inputs and the instruction word. The successors are 0→1, 2→3, 10→14, 11→17, 14→15 and 15→16, and each of 5, 6, 7, 9, 12, 13 and 18 goes to 0.
- R4: Address 4 goes to 5 plus the unsigned opcode in `ir_word[15:10]`. Bits 9:0 of `ir_word` and all status inputs have no effect on the result.
- R5: A memory-access word of R2 goes to itself, leaving `upc` unchanged, while `mem_wait` is 1.
- R6: Address 8 goes to 0 when `st_carry` is 1 and to 13 when it is 0. `st_sign`, `st_ovf` and `mem_wait` have no effect there.
- R7: Any address above 18 that is not in the program, including dispatch targets of opcodes 14 to 63, goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_word | input | 16 | Instruction register contents; bits 15:10 are the opcode |
| st_carry | input | 1 | ALU carry-out status |
| st_sign | input | 1 | ALU result sign status |
| st_ovf | input | 1 | ALU overflow status |
| mem_wait | input | 1 | Memory busy status |
| upc | output | 8 | Current micro-PC |

## Verification
The bound checker checks the following on every cycle: the wait self-loops and their exits, the dispatch sum against the opcode from the previous cycle, both outcomes of the branch test at address 8, the fixed successors of the fetch steps, and the return to 0 from unpopulated addresses. The bench's scenarios cover the rest. These include the full fetch/dispatch/execute walks for every opcode of the sample program, and dispatches to opcodes beyond the table that land in the branch step or in empty space. They also show that the low instruction bits and the unselected status lines have no effect, and that a reset in the middle of an access loop returns the sequencer to address 0.

// File: rtl/microseq_pkg.sv
// Package: shared widths, status-select codes, control-word layout and the
// built-in next-address table of the sample 19-word program.
// Assumes the address width exceeds the opcode width.
package microseq_pkg;

    parameter int unsigned UADDR_W = 8;
    parameter int unsigned OPC_W   = 6;
    parameter int unsigned NSTAT   = 4;
    localparam int unsigned SEL_W  = $clog2(NSTAT);

    typedef logic [UADDR_W-1:0] uaddr_t;

    // Status-line selector; values index the status vector in the top.
    typedef enum logic [SEL_W-1:0] {
        SEL_CARRY = 2'd0,
        SEL_SIGN  = 2'd1,
        SEL_OVF   = 2'd2,
        SEL_WAIT  = 2'd3
    } stat_sel_e;

    typedef struct packed {
        logic      dispatch;
        stat_sel_e sel;
        uaddr_t    on_true;
        uaddr_t    on_false;
    } seq_word_t;

    // Program labels.
    localparam uaddr_t LBL_FETCH0 = 8'd0;
    localparam uaddr_t LBL_FETCH1 = 8'd1;
    localparam uaddr_t LBL_FETCH2 = 8'd2;
    localparam uaddr_t LBL_FETCH3 = 8'd3;
    localparam uaddr_t LBL_DECODE = 8'd4;
    localparam uaddr_t LBL_OPTAB  = 8'd5;
    localparam uaddr_t LBL_BZ     = 8'd8;
    localparam uaddr_t LBL_ST     = 8'd10;
    localparam uaddr_t LBL_LD     = 8'd11;
    localparam uaddr_t LBL_BRANCH = 8'd13;
    localparam uaddr_t LBL_ST_A   = 8'd14;
    localparam uaddr_t LBL_ST_B   = 8'd15;
    localparam uaddr_t LBL_ST_WR  = 8'd16;
    localparam uaddr_t LBL_LD_RD  = 8'd17;
    localparam uaddr_t LBL_LD_WB  = 8'd18;

    // Builds an unconditional jump: both candidates equal, selector unused.
    function automatic seq_word_t jump_to(input uaddr_t dst);
        return '{dispatch: 1'b0, sel: SEL_CARRY, on_true: dst, on_false: dst};
    endfunction

    // Builds a two-way branch on one status line.
    function automatic seq_word_t branch_on(input stat_sel_e s,
                                            input uaddr_t t, input uaddr_t f);
        return '{dispatch: 1'b0, sel: s, on_true: t, on_false: f};
    endfunction

    // Next-address fields of the sample program; empty addresses go to 0.
    function automatic seq_word_t seq_table(input uaddr_t a);
        seq_word_t w;
        case (a)
            LBL_FETCH0: w = jump_to(LBL_FETCH1);
            LBL_FETCH1: w = branch_on(SEL_WAIT, LBL_FETCH1, LBL_FETCH2);
            LBL_FETCH2: w = jump_to(LBL_FETCH3);
            LBL_FETCH3: w = branch_on(SEL_WAIT, LBL_FETCH3, LBL_DECODE);
            LBL_DECODE: w = '{dispatch: 1'b1, sel: SEL_CARRY,
                              on_true: LBL_OPTAB, on_false: LBL_OPTAB};
            LBL_BZ:     w = branch_on(SEL_CARRY, LBL_FETCH0, LBL_BRANCH);
            LBL_ST:     w = jump_to(LBL_ST_A);
            LBL_LD:     w = jump_to(LBL_LD_RD);
            LBL_ST_A:   w = jump_to(LBL_ST_B);
            LBL_ST_B:   w = jump_to(LBL_ST_WR);
            LBL_ST_WR:  w = branch_on(SEL_WAIT, LBL_ST_WR, LBL_FETCH0);
            LBL_LD_RD:  w = branch_on(SEL_WAIT, LBL_LD_RD, LBL_LD_WB);
            default:    w = jump_to(LBL_FETCH0);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/microseq_store.sv
// Control-store next-address lookup.
// Returns the sequencing fields of the word at the current micro-PC.
// Purely combinational; the contents come from the package table.
module microseq_store
    import microseq_pkg::*;
(
    input  uaddr_t    addr,
    output seq_word_t word
);

    // Table lookup for the current address.
    always_comb begin
        word = seq_table(addr);
    end

endmodule

// File: rtl/microseq_cond.sv
// Status-line multiplexer.
// Picks one line of the status vector by the selector of the current word.
// Assumes the vector is ordered to match the selector codes.
module microseq_cond
    import microseq_pkg::*;
#(
    parameter int unsigned N = NSTAT
) (
    input  logic [N-1:0] status,
    input  stat_sel_e    sel,
    output logic         hit
);

    logic [N-1:0] pick;

    // One AND gate per status line, decoded from the selector.
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign pick[i] = status[i] & (sel == stat_sel_e'(i));
    end

    // Reduce the gated lines into the tested condition.
    always_comb begin
        hit = |pick;
    end

endmodule

// File: rtl/microseq_next.sv
// Next-address former.
// Chooses the true or false candidate, then optionally adds the opcode.
// Assumes the opcode is unsigned and the sum wraps at the address width.
module microseq_next
    import microseq_pkg::*;
#(
    parameter int unsigned AW = UADDR_W,
    parameter int unsigned OW = OPC_W
) (
    input  seq_word_t        word,
    input  logic             hit,
    input  logic [OW-1:0]    opcode,
    output logic [AW-1:0]    nxt
);

    localparam int unsigned PAD_W = AW - OW;

    logic [AW-1:0] base;

    // Two-way selection, then dispatch offset when the word asks for it.
    always_comb begin
        base = hit ? word.on_true : word.on_false;
        nxt  = word.dispatch ? AW'(base + {{PAD_W{1'b0}}, opcode}) : base;
    end

endmodule

// File: rtl/microseq_top.sv
// Two-way microsequencer top.
// Holds the micro-PC and advances it on every clock edge. There is no stall
// input: waiting is encoded as self-loops in the control program.
// Assumes a synchronous, active-low reset.
module microseq_top
    import microseq_pkg::*;
#(
    parameter int unsigned IR_W    = 16,
    parameter int unsigned OPC_LSB = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IR_W-1:0]    ir_word,
    input  logic               st_carry,
    input  logic               st_sign,
    input  logic               st_ovf,
    input  logic               mem_wait,
    output logic [UADDR_W-1:0] upc
);

    localparam int unsigned OPC_MSB = OPC_LSB + OPC_W - 1;

    seq_word_t          cur_word;
    logic [NSTAT-1:0]   status_vec;
    logic               cond_hit;
    logic [UADDR_W-1:0] upc_nxt;

    // Status lines in selector order.
    assign status_vec = {mem_wait, st_ovf, st_sign, st_carry};

    microseq_store u_store (
        .addr (upc),
        .word (cur_word)
    );

    microseq_cond #(.N(NSTAT)) u_cond (
        .status (status_vec),
        .sel    (cur_word.sel),
        .hit    (cond_hit)
    );

    microseq_next #(.AW(UADDR_W), .OW(OPC_W)) u_next (
        .word   (cur_word),
        .hit    (cond_hit),
        .opcode (ir_word[OPC_MSB:OPC_LSB]),
        .nxt    (upc_nxt)
    );

    // Micro-PC register with synchronous reset to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= '0;
        else        upc <= upc_nxt;
    end

endmodule

// File: rtl/microseq_chk.sv
// Checker for microseq_top: sequencing properties of the sample program,
// attached by bind.
module microseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ir_word,
    input logic        st_carry,
    input logic        mem_wait,
    input logic [7:0]  upc
);

    AST_FETCH_EXIT:   assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd3 && !mem_wait) |=> (upc == 8'd4));                      // R2
    AST_LOAD_EXIT:    assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd17 && !mem_wait) |=> (upc == 8'd18));                    // R2
    AST_FETCH_START:  assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd0) |=> (upc == 8'd1));                                   // R3
    AST_STORE_CHAIN:  assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd14) |=> (upc == 8'd15));                                 // R3
    AST_DISPATCH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd4) |=> (upc == 8'(8'd5 + {2'b00, $past(ir_word[15:10])}))); // R4
    AST_WAIT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
        ((upc == 8'd1 || upc == 8'd16) && mem_wait) |=> $stable(upc));      // R5
    AST_BZ_TAKEN:     assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd8 && !st_carry) |=> (upc == 8'd13));                     // R6
    AST_BZ_SKIP:      assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 8'd8 && st_carry) |=> (upc == 8'd0));                       // R6
    AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (upc > 8'd18) |=> (upc == 8'd0));                                   // R7

endmodule

bind microseq_top microseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_word  (ir_word),
    .st_carry (st_carry),
    .mem_wait (mem_wait),
    .upc      (upc)
);

// File: tb/microseq_top_bench.sv
// Bench for microseq_top: behavioural successor model compared every cycle.
module microseq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ir_word;
    logic        st_carry, st_sign, st_ovf, mem_wait;
    logic [7:0]  upc;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    microseq_top u_microseq_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir_word  (ir_word),
        .st_carry (st_carry),
        .st_sign  (st_sign),
        .st_ovf   (st_ovf),
        .mem_wait (mem_wait),
        .upc      (upc)
    );

    // Successor written from the program listing, with requirement tag.
    function automatic int model_next(input int u, input bit c, input bit w,
                                      input int opc, output string tag);
        int n;
        case (u)
            0:  begin n = 1;  tag = "R3"; end
            2:  begin n = 3;  tag = "R3"; end
            10: begin n = 14; tag = "R3"; end
            11: begin n = 17; tag = "R3"; end
            14: begin n = 15; tag = "R3"; end
            15: begin n = 16; tag = "R3"; end
            5, 6, 7, 9, 12, 13, 18: begin n = 0; tag = "R3"; end
            1:  begin n = w ? 1  : 2;  tag = w ? "R5" : "R2"; end
            3:  begin n = w ? 3  : 4;  tag = w ? "R5" : "R2"; end
            16: begin n = w ? 16 : 0;  tag = w ? "R5" : "R2"; end
            17: begin n = w ? 17 : 18; tag = w ? "R5" : "R2"; end
            4:  begin n = (5 + opc) % 256; tag = "R4"; end
            8:  begin n = c ? 0 : 13; tag = "R6"; end
            default: begin n = 0; tag = "R7"; end
        endcase
        return n;
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int    exp_upc;
        string tag;
        int    steer_list[13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 19, 40, 63, 13};
        int    steer_idx = 0;
        int    opc;

        rst_n = 1'b0; ir_word = '0;
        st_carry = 0; st_sign = 0; st_ovf = 0; mem_wait = 0;
        exp_upc = 0; tag = "R1";
        repeat (3) @(negedge clk);

        for (int cyc = 0; cyc < 6000; cyc++) begin
            // Compare the value registered at the last rising edge.
            total++;
            if (upc !== 8'(exp_upc)) begin
                bad++;
                $display("FAIL %s: cycle %0d actual upc=%0d expected=%0d",
                         tag, cyc, upc, exp_upc);
            end

            // Drive the inputs for the next edge.
            rst_n    = !(cyc >= 3000 && cyc < 3003);
            mem_wait = ($urandom_range(0, 2) == 0);
            st_carry = $urandom_range(0, 1);
            st_sign  = $urandom_range(0, 1);
            st_ovf   = $urandom_range(0, 1);
            ir_word  = 16'($urandom);
            if (exp_upc == 4 && steer_idx < 13) begin
                ir_word[15:10] = 6'(steer_list[steer_idx]);
                steer_idx++;
            end
            opc = int'(ir_word[15:10]);

            if (!rst_n) begin
                exp_upc = 0; tag = "R1";
            end else begin
                exp_upc = model_next(exp_upc, st_carry, mem_wait, opc, tag);
            end
            @(negedge clk);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule